// File: doc/BRIEF.md
# Time-Shared Cascaded Biquad Filter Engine

This block runs a recursive filter on several independent channels. The filter is a chain of second-order sections. Samples arrive one at a time, each tagged with a channel number. The engine pushes each sample through every section of that channel's chain in turn. One signed multiplier and one saturating adder do all the arithmetic, one product per clock cycle. Each section takes four cycles: two feedback products and two feed-forward products. The section's input scale factor is a power of two, so it costs an arithmetic right shift and no multiply.

Each section uses a direct-form-II recursion. The intermediate value is u = (x >>> s) − a1·w1 − a2·w2. The section output is y = u + b1·w1 + b2·w2. After each section, w2 takes the old w1 and w1 takes u. Each section's output is the next section's input. The delay state and the coefficient sets are held in register arrays indexed by channel and section. Coefficients are written through a simple write port; how they are designed is outside this block.

The engine raises a busy flag while a sample is in flight and refuses new samples until the flag drops. It then delivers an 18-bit result, tagged with the channel, under a one-cycle valid strobe.

Top module: `biquad_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` and `busy` are 0. Reset clears every coefficient field and every delay value to zero. With all coefficients zero, each sample comes out unchanged.
- R2: A sample is taken on a clock edge where `in_valid` is 1, `busy` is 0 and `in_ch` < NUM_CH. `busy` is then high for exactly 4·NUM_SEC cycles. Whatever appears on `in_valid`, `in_ch` and `in_data` while `busy` is high is ignored.
- R3: Coefficients are signed 18-bit two's complement with 16 fraction bits (65536 = 1.0). Each product is the 52-bit delay value times the coefficient, arithmetically shifted right by 16. Each section computes u = (x >>> s) − a1·w1 − a2·w2 and then y = u + b1·w1 + b2·w2, one product per cycle.
- R4: The section input is arithmetically shifted right by the section's 4-bit shift field (0 to 15) before the first accumulation. No multiply is used for this scale factor.
- R5: After a section is processed, that channel's w2 for the section takes the old w1, and w1 takes u. The section output y is the input of the next section. The last section's y is the result.
- R6: Every channel has its own delay state and coefficient sets. Processing one channel never changes another channel's output.
- R7: Every product and every accumulation saturates to the signed 52-bit range [−2^51, 2^51−1] and never wraps.
- R8: An input sample enters the datapath multiplied by 2^26. The result is (y + 2^25) >>> 26, which rounds half toward positive infinity, then clamped to [−131072, 131071].
- R9: `out_valid` is high for exactly one cycle, starting 4·NUM_SEC clock edges after the edge that took the sample. At that time `out_ch` equals the sample's channel.
- R10: A coefficient write on an edge with `coef_we` high replaces the whole set for (`coef_ch`, `coef_sec`). It takes effect from the next sample taken. Writes whose channel or section index is out of range are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ch | input | CH_W (2) | Channel of offered sample |
| in_data | input | IN_W (18) | Signed input sample |
| busy | output | 1 | Sample in flight; new samples refused |
| coef_we | input | 1 | Coefficient set write strobe |
| coef_ch | input | CH_W (2) | Channel of coefficient write |
| coef_sec | input | SEC_W (2) | Section of coefficient write |
| coef_fb1 | input | 18 | Feedback coefficient a1 |
| coef_fb2 | input | 18 | Feedback coefficient a2 |
| coef_ff1 | input | 18 | Feed-forward coefficient b1 |
| coef_ff2 | input | 18 | Feed-forward coefficient b2 |
| coef_shift | input | 4 | Right-shift amount for section input |
| out_valid | output | 1 | One-cycle result strobe |
| out_ch | output | CH_W (2) | Channel of result |
| out_data | output | IN_W (18) | Rounded, clamped signed result |

## Verification
The bench checks outputs against an independent fixed-point model of the cascade. It also checks hand-computed values that a model could get wrong in the same way.

- **Rounding and shift.** Halves of opposite sign, such as 12.5 and −12.5, tell round-half-up apart from truncation or symmetric rounding. A 15-bit shift of a full-scale input shows whether the shift is arithmetic.
- **Delay line.** An equal-tap feed-forward section exposes a swapped or missing w2 ← w1 update: the running sums come out wrong.
- **Saturation.** A feedback gain of −2.0 drives the accumulator to full scale in both directions. A wrapping adder would flip the output sign.
- **Input while busy.** Changed input data held on the port during a busy window must produce no extra strobe. The neighbouring channel, whose state that data could have corrupted, must still match the model afterwards.
- **Channel isolation.** Interleaved channels, one set to pass-through, catch shared or mis-indexed state.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    localparam int ACC_W     = 52;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 16;
    localparam int SHIFT_W   = 4;
    localparam int PROD_W    = ACC_W + COEF_W;

    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t               fb1;
        coef_t               fb2;
        coef_t               ff1;
        coef_t               ff2;
        logic [SHIFT_W-1:0]  gain_sh;
    } sos_coef_t;

    typedef enum logic [1:0] {
        PH_FB1 = 2'd0,
        PH_FB2 = 2'd1,
        PH_FF1 = 2'd2,
        PH_FF2 = 2'd3
    } phase_e;

    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    localparam logic signed [ACC_W+1:0] SUM_MAX = {3'b000, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W+1:0] SUM_MIN = {3'b111, {(ACC_W-1){1'b0}}};

    localparam logic signed [PROD_W-1:0] PRD_MAX = {{(COEF_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] PRD_MIN = {{(COEF_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    // Saturating add or subtract in the accumulator range.
    function automatic acc_t sat_sum(acc_t a, acc_t b, logic sub);
        logic signed [ACC_W+1:0] ea;
        logic signed [ACC_W+1:0] eb;
        logic signed [ACC_W+1:0] s;
        ea = {{2{a[ACC_W-1]}}, a};
        eb = {{2{b[ACC_W-1]}}, b};
        s  = sub ? (ea - eb) : (ea + eb);
        if (s > SUM_MAX)      return ACC_MAX;
        else if (s < SUM_MIN) return ACC_MIN;
        else                  return s[ACC_W-1:0];
    endfunction

    // Fixed-point product rescaled by the coefficient fraction, clamped.
    function automatic acc_t scaled_mul(acc_t w, coef_t c);
        logic signed [PROD_W-1:0] p;
        logic signed [PROD_W-1:0] q;
        p = PROD_W'(w) * PROD_W'(c);
        q = p >>> COEF_FRAC;
        if (q > PRD_MAX)      return ACC_MAX;
        else if (q < PRD_MIN) return ACC_MIN;
        else                  return q[ACC_W-1:0];
    endfunction

endpackage

// File: rtl/biquad_coef_mem.sv
module biquad_coef_mem
    import biquad_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_SEC = 3,
    parameter int CH_W    = 2,
    parameter int SEC_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [SEC_W-1:0] wr_sec,
    input  sos_coef_t        wr_set,
    input  logic [CH_W-1:0]  rd_ch,
    input  logic [SEC_W-1:0] rd_sec,
    output sos_coef_t        rd_set
);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SEC - 1);

    sos_coef_t bank [NUM_CH][NUM_SEC];

    logic wr_ok;
    assign wr_ok = wr_en && (wr_ch <= LAST_CH) && (wr_sec <= LAST_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int s = 0; s < NUM_SEC; s++)
                    bank[c][s] <= '0;
        end else if (wr_ok) begin
            bank[wr_ch][wr_sec] <= wr_set;
        end
    end

    assign rd_set = bank[rd_ch][rd_sec];

    // R10: an accepted write is visible at the read side on the next cycle
    p_coef_write_r10: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (bank[$past(wr_ch)][$past(wr_sec)] == $past(wr_set)));

endmodule

// File: rtl/biquad_state_mem.sv
module biquad_state_mem
    import biquad_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_SEC = 3,
    parameter int CH_W    = 2,
    parameter int SEC_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [CH_W-1:0]  ch,
    input  logic [SEC_W-1:0] sec,
    input  acc_t             u_new,
    output acc_t             d1,
    output acc_t             d2
);
    acc_t dly1 [NUM_CH][NUM_SEC];
    acc_t dly2 [NUM_CH][NUM_SEC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int s = 0; s < NUM_SEC; s++) begin
                    dly1[c][s] <= '0;
                    dly2[c][s] <= '0;
                end
        end else if (upd) begin
            dly2[ch][sec] <= dly1[ch][sec];
            dly1[ch][sec] <= u_new;
        end
    end

    assign d1 = dly1[ch][sec];
    assign d2 = dly2[ch][sec];

    // R5: the newest delay takes u, the older one takes the previous newest
    p_dly1_takes_u_r5: assert property (@(posedge clk) disable iff (rst)
        upd |=> (dly1[$past(ch)][$past(sec)] == $past(u_new)));
    p_dly2_takes_d1_r5: assert property (@(posedge clk) disable iff (rst)
        upd |=> (dly2[$past(ch)][$past(sec)] == $past(d1)));

endmodule

// File: rtl/biquad_mac.sv
module biquad_mac
    import biquad_pkg::*;
(
    input  phase_e    phase,
    input  acc_t      sec_in,
    input  acc_t      acc,
    input  acc_t      d1,
    input  acc_t      d2,
    input  sos_coef_t cset,
    output acc_t      acc_nx
);
    acc_t  op_w;
    coef_t op_c;
    acc_t  base;
    acc_t  prod;
    logic  sub;

    always_comb begin
        unique case (phase)
            PH_FB1:  begin op_w = d1; op_c = cset.fb1; end
            PH_FB2:  begin op_w = d2; op_c = cset.fb2; end
            PH_FF1:  begin op_w = d1; op_c = cset.ff1; end
            default: begin op_w = d2; op_c = cset.ff2; end
        endcase
        base   = (phase == PH_FB1) ? (sec_in >>> cset.gain_sh) : acc;
        sub    = (phase == PH_FB1) || (phase == PH_FB2);
        prod   = scaled_mul(op_w, op_c);
        acc_nx = sat_sum(base, prod, sub);
    end

endmodule

// File: rtl/biquad_seq.sv
module biquad_seq
    import biquad_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_SEC = 3,
    parameter int CH_W    = 2,
    parameter int SEC_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CH_W-1:0]  req_ch,
    output logic             take,
    output logic             busy,
    output logic [CH_W-1:0]  cur_ch,
    output logic [SEC_W-1:0] cur_sec,
    output phase_e           phase,
    output logic             sec_end,
    output logic             last
);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SEC - 1);

    assign take    = req && !busy && (req_ch <= LAST_CH);
    assign sec_end = busy && (phase == PH_FF2);
    assign last    = sec_end && (cur_sec == LAST_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur_ch  <= '0;
            cur_sec <= '0;
            phase   <= PH_FB1;
        end else if (!busy) begin
            if (take) begin
                busy    <= 1'b1;
                cur_ch  <= req_ch;
                cur_sec <= '0;
                phase   <= PH_FB1;
            end
        end else if (phase == PH_FF2) begin
            phase <= PH_FB1;
            if (cur_sec == LAST_SEC) busy <= 1'b0;
            else                     cur_sec <= cur_sec + 1'b1;
        end else begin
            phase <= phase_e'(phase + 2'd1);
        end
    end

    // R2: a taken sample raises busy
    p_take_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);
    // R2: the channel in flight is frozen while busy
    p_ch_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_ch));
    // R2: busy drops right after the last phase of the last section
    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
    // R3: the four phases run in order inside a section
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_FF2) |=> (busy && phase == phase_e'($past(phase) + 2'd1)));

endmodule

// File: rtl/biquad_engine.sv
module biquad_engine
    import biquad_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_SEC = 3,
    parameter int IN_W    = 18,
    parameter int HEAD    = 8,
    localparam int CH_W   = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1,
    localparam int SEC_W  = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    localparam int OUT_W  = IN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_ch,
    input  logic signed [IN_W-1:0]   in_data,
    output logic                     busy,
    input  logic                     coef_we,
    input  logic [CH_W-1:0]          coef_ch,
    input  logic [SEC_W-1:0]         coef_sec,
    input  logic signed [COEF_W-1:0] coef_fb1,
    input  logic signed [COEF_W-1:0] coef_fb2,
    input  logic signed [COEF_W-1:0] coef_ff1,
    input  logic signed [COEF_W-1:0] coef_ff2,
    input  logic [SHIFT_W-1:0]       coef_shift,
    output logic                     out_valid,
    output logic [CH_W-1:0]          out_ch,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int SCALE = ACC_W - IN_W - HEAD;

    localparam logic [ACC_W:0] HALF_LSB =
        {{(ACC_W-SCALE+1){1'b0}}, 1'b1, {(SCALE-1){1'b0}}};
    localparam logic signed [ACC_W:0] OMAX_E =
        {{(ACC_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] OMIN_E =
        {{(ACC_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

    logic             take;
    logic [CH_W-1:0]  cur_ch;
    logic [SEC_W-1:0] cur_sec;
    phase_e           phase;
    logic             sec_end;
    logic             last;

    sos_coef_t wr_set;
    sos_coef_t cset;
    acc_t      d1, d2;
    acc_t      sec_in_q, acc_q, u_q, acc_nx;
    acc_t      x_ext;

    logic signed [ACC_W:0]   r_ext;
    logic signed [ACC_W:0]   r_sh;
    logic signed [OUT_W-1:0] rounded;

    assign wr_set = '{fb1: coef_fb1, fb2: coef_fb2, ff1: coef_ff1,
                      ff2: coef_ff2, gain_sh: coef_shift};
    assign x_ext  = {{HEAD{in_data[IN_W-1]}}, in_data, {SCALE{1'b0}}};

    biquad_seq #(.NUM_CH(NUM_CH), .NUM_SEC(NUM_SEC), .CH_W(CH_W), .SEC_W(SEC_W)) u_seq (
        .clk(clk), .rst(rst), .req(in_valid), .req_ch(in_ch), .take(take),
        .busy(busy), .cur_ch(cur_ch), .cur_sec(cur_sec), .phase(phase),
        .sec_end(sec_end), .last(last)
    );

    biquad_coef_mem #(.NUM_CH(NUM_CH), .NUM_SEC(NUM_SEC), .CH_W(CH_W), .SEC_W(SEC_W)) u_coef (
        .clk(clk), .rst(rst), .wr_en(coef_we), .wr_ch(coef_ch), .wr_sec(coef_sec),
        .wr_set(wr_set), .rd_ch(cur_ch), .rd_sec(cur_sec), .rd_set(cset)
    );

    biquad_state_mem #(.NUM_CH(NUM_CH), .NUM_SEC(NUM_SEC), .CH_W(CH_W), .SEC_W(SEC_W)) u_state (
        .clk(clk), .rst(rst), .upd(sec_end), .ch(cur_ch), .sec(cur_sec),
        .u_new(u_q), .d1(d1), .d2(d2)
    );

    biquad_mac u_mac (
        .phase(phase), .sec_in(sec_in_q), .acc(acc_q), .d1(d1), .d2(d2),
        .cset(cset), .acc_nx(acc_nx)
    );

    always_comb begin
        r_ext = {acc_nx[ACC_W-1], acc_nx} + HALF_LSB;
        r_sh  = r_ext >>> SCALE;
        if (r_sh > OMAX_E)      rounded = OMAX_E[OUT_W-1:0];
        else if (r_sh < OMIN_E) rounded = OMIN_E[OUT_W-1:0];
        else                    rounded = r_sh[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_in_q  <= '0;
            acc_q     <= '0;
            u_q       <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (take) sec_in_q <= x_ext;
            if (busy) begin
                acc_q <= acc_nx;
                if (phase == PH_FB2) u_q <= acc_nx;
                if (sec_end) sec_in_q <= acc_nx;
                if (last) begin
                    out_valid <= 1'b1;
                    out_ch    <= cur_ch;
                    out_data  <= rounded;
                end
            end
        end
    end

    // R9: result strobe lasts one cycle
    p_out_single_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R9: result appears as the busy window closes
    p_out_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!busy && $past(busy)));
    // R9: result carries the channel that was in flight
    p_out_ch_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_ch == $past(cur_ch)));

endmodule

// File: tb/biquad_engine_tb.sv
`timescale 1ns/1ps
module biquad_engine_tb_top;
    localparam int NCH = 4;
    localparam int NS  = 3;
    localparam int LAT = 4 * NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_ch = '0;
    logic signed [17:0] in_data = '0;
    logic busy;
    logic coef_we = 1'b0;
    logic [1:0] coef_ch = '0;
    logic [1:0] coef_sec = '0;
    logic signed [17:0] coef_fb1 = '0, coef_fb2 = '0, coef_ff1 = '0, coef_ff2 = '0;
    logic [3:0] coef_shift = '0;
    logic out_valid;
    logic [1:0] out_ch;
    logic signed [17:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    biquad_engine dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
        .busy(busy), .coef_we(coef_we), .coef_ch(coef_ch), .coef_sec(coef_sec),
        .coef_fb1(coef_fb1), .coef_fb2(coef_fb2), .coef_ff1(coef_ff1), .coef_ff2(coef_ff2),
        .coef_shift(coef_shift), .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
    );

    // ---------------- reference model ----------------
    logic signed [51:0] m_w1 [NCH][NS];
    logic signed [51:0] m_w2 [NCH][NS];
    int m_a1 [NCH][NS], m_a2 [NCH][NS], m_b1 [NCH][NS], m_b2 [NCH][NS], m_sh [NCH][NS];

    localparam logic signed [127:0] BMAX = (128'sd1 <<< 51) - 128'sd1;
    localparam logic signed [127:0] BMIN = -(128'sd1 <<< 51);

    function automatic logic signed [51:0] b_sat(input logic signed [127:0] v);
        if (v > BMAX) return BMAX[51:0];
        if (v < BMIN) return BMIN[51:0];
        return v[51:0];
    endfunction

    function automatic logic signed [51:0] b_mul(input logic signed [51:0] w, input int c);
        logic signed [127:0] p;
        p = 128'(w) * 128'(c);
        p = p >>> 16;
        return b_sat(p);
    endfunction

    task automatic model_clear();
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < NS; s++) begin
                m_w1[c][s] = '0; m_w2[c][s] = '0;
                m_a1[c][s] = 0; m_a2[c][s] = 0; m_b1[c][s] = 0; m_b2[c][s] = 0; m_sh[c][s] = 0;
            end
    endtask

    task automatic model_step(input int ch, input int x, output logic signed [17:0] y);
        logic signed [51:0] v, acc, u;
        logic signed [127:0] r;
        v = 52'(x) <<< 26;
        for (int s = 0; s < NS; s++) begin
            acc = b_sat(128'(v >>> m_sh[ch][s]) - 128'(b_mul(m_w1[ch][s], m_a1[ch][s])));
            acc = b_sat(128'(acc) - 128'(b_mul(m_w2[ch][s], m_a2[ch][s])));
            u   = acc;
            acc = b_sat(128'(acc) + 128'(b_mul(m_w1[ch][s], m_b1[ch][s])));
            acc = b_sat(128'(acc) + 128'(b_mul(m_w2[ch][s], m_b2[ch][s])));
            m_w2[ch][s] = m_w1[ch][s];
            m_w1[ch][s] = u;
            v = acc;
        end
        r = (128'(v) + (128'sd1 <<< 25)) >>> 26;
        if (r > 128'sd131071) r = 128'sd131071;
        if (r < -128'sd131072) r = -128'sd131072;
        y = r[17:0];
    endtask

    // ---------------- helpers ----------------
    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_eq("R1", "out_valid in reset", longint'(out_valid), 0);
        check_eq("R1", "busy in reset", longint'(busy), 0);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(posedge clk); #1;
        check_eq("R1", "out_valid after reset", longint'(out_valid), 0);
        check_eq("R1", "busy after reset", longint'(busy), 0);
    endtask

    task automatic set_coef(input int ch, input int sec, input int a1, input int a2,
                            input int b1, input int b2, input int sh);
        @(negedge clk);
        coef_we = 1'b1; coef_ch = 2'(ch); coef_sec = 2'(sec);
        coef_fb1 = 18'(a1); coef_fb2 = 18'(a2); coef_ff1 = 18'(b1); coef_ff2 = 18'(b2);
        coef_shift = 4'(sh);
        @(posedge clk); #1;
        coef_we = 1'b0;
        m_a1[ch][sec] = a1; m_a2[ch][sec] = a2; m_b1[ch][sec] = b1; m_b2[ch][sec] = b2;
        m_sh[ch][sec] = sh;
    endtask

    // Offer one sample, follow it to its result and compare with the model.
    task automatic run_sample(input int ch, input int x, input string req, input bit poke,
                              output logic signed [17:0] got);
        logic signed [17:0] exp;
        int cnt, bcnt;
        model_step(ch, x, exp);
        @(negedge clk);
        in_valid = 1'b1; in_ch = 2'(ch); in_data = 18'(x);
        @(posedge clk); #1;
        if (poke) begin
            in_ch = 2'((ch + 1) % NCH); in_data = 18'sd54321;
        end else begin
            in_valid = 1'b0;
        end
        cnt = 0; bcnt = 0;
        while (!out_valid && cnt < 40) begin
            if (busy) bcnt++;
            @(posedge clk); #1;
            cnt++;
        end
        in_valid = 1'b0;
        got = out_data;
        check_eq("R9", "result latency", cnt, LAT);
        check_eq("R2", "busy length", bcnt, LAT);
        check_eq("R9", "result channel", longint'(out_ch), ch);
        check_eq(req, "result value", longint'(out_data), longint'(exp));
        @(posedge clk); #1;
        check_eq("R9", "strobe is single", longint'(out_valid), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_passthrough();
        logic signed [17:0] g;
        do_reset();
        run_sample(0, 1000, "R1", 1'b0, g);
        check_eq("R1", "zero coefs pass 1000", longint'(g), 1000);
        run_sample(0, -131072, "R8", 1'b0, g);
        check_eq("R8", "negative full scale", longint'(g), -131072);
        run_sample(3, 131071, "R8", 1'b0, g);
        check_eq("R8", "positive full scale", longint'(g), 131071);
    endtask

    task automatic t_shift_round();
        logic signed [17:0] g;
        do_reset();
        set_coef(0, 0, 0, 0, 0, 0, 3);
        run_sample(0, 100, "R4", 1'b0, g);
        check_eq("R8", "12.5 rounds up", longint'(g), 13);
        run_sample(0, -100, "R4", 1'b0, g);
        check_eq("R8", "-12.5 rounds up", longint'(g), -12);
        set_coef(0, 0, 0, 0, 0, 0, 15);
        run_sample(0, 131071, "R4", 1'b0, g);
        check_eq("R4", "shift 15 of max", longint'(g), 4);
        run_sample(0, -131072, "R4", 1'b0, g);
        check_eq("R4", "shift 15 of min", longint'(g), -4);
    endtask

    task automatic t_delay_line();
        logic signed [17:0] g;
        do_reset();
        set_coef(0, 0, 0, 0, 65536, 65536, 0);
        run_sample(0, 10, "R5", 1'b0, g);
        check_eq("R5", "sum after 10", longint'(g), 10);
        run_sample(0, 20, "R5", 1'b0, g);
        check_eq("R5", "sum after 20", longint'(g), 30);
        run_sample(0, 30, "R5", 1'b0, g);
        check_eq("R5", "sum after 30", longint'(g), 60);
        run_sample(0, 0, "R5", 1'b0, g);
        check_eq("R5", "sum after 0", longint'(g), 50);
    endtask

    task automatic t_cascade();
        logic signed [17:0] g;
        int xs [10] = '{20000, 0, 0, 0, -15000, 7777, 0, 131071, -131072, 0};
        do_reset();
        set_coef(1, 0, -78643, 32768, 19661, -16384, 1);
        set_coef(1, 1, 26214, -6554, -65536, 45875, 0);
        set_coef(1, 2, 0, 0, 98304, 0, 2);
        set_coef(1, 3, 65536, 65536, 65536, 65536, 5);
        foreach (xs[i]) run_sample(1, xs[i], "R3", 1'b0, g);
    endtask

    task automatic t_channels();
        logic signed [17:0] g;
        do_reset();
        set_coef(1, 0, -78643, 32768, 19661, -16384, 1);
        set_coef(1, 1, 26214, -6554, -65536, 45875, 0);
        for (int k = 0; k < 6; k++) begin
            run_sample(1, 9000 - 4000 * k, "R6", 1'b0, g);
            run_sample(2, 321 * k - 700, "R6", 1'b0, g);
            check_eq("R6", "idle channel passes", longint'(g), 321 * k - 700);
        end
    endtask

    task automatic t_busy_ignore();
        logic signed [17:0] g;
        do_reset();
        set_coef(0, 0, -65536, 0, 0, 0, 0);
        set_coef(1, 0, -32768, 0, 32768, 0, 0);
        run_sample(0, 5000, "R2", 1'b1, g);
        run_sample(1, 3000, "R2", 1'b0, g);
        run_sample(0, -2000, "R2", 1'b1, g);
        run_sample(1, 100, "R2", 1'b0, g);
    endtask

    task automatic t_saturate();
        logic signed [17:0] g;
        do_reset();
        set_coef(3, 0, -131072, 0, 0, 0, 0);
        set_coef(2, 0, -131072, 0, 0, 0, 0);
        for (int k = 0; k < 14; k++) begin
            run_sample(3, 131071, "R7", 1'b0, g);
            if (g < 0) check_eq("R7", "no wrap positive", longint'(g), 131071);
        end
        check_eq("R7", "positive rail", longint'(g), 131071);
        for (int k = 0; k < 14; k++) begin
            run_sample(2, -131072, "R7", 1'b0, g);
            if (g > 0) check_eq("R7", "no wrap negative", longint'(g), -131072);
        end
        check_eq("R7", "negative rail", longint'(g), -131072);
    endtask

    task automatic t_coef_range();
        logic signed [17:0] g;
        do_reset();
        set_coef(0, 3, 65536, 65536, 65536, 65536, 9);
        m_a1[0][0] = 0;
        run_sample(0, 4321, "R10", 1'b0, g);
        check_eq("R10", "out-of-range section write dropped", longint'(g), 4321);
        set_coef(0, 2, 0, 0, 0, 0, 1);
        run_sample(0, 4321, "R10", 1'b0, g);
        check_eq("R10", "new set used on next sample", longint'(g), 2161);
    endtask

    initial begin
        t_passthrough();
        t_shift_round();
        t_delay_line();
        t_cascade();
        t_channels();
        t_busy_ignore();
        t_saturate();
        t_coef_range();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule